// File: doc/BRIEF.md
# Burst-Write Sink with Target Disconnect

This block is the target side of a parallel shared bus with active-low, clock-sampled handshakes. It accepts memory-write bursts from an external bus master into a small write FIFO. It watches each transaction start, decodes the command and the address, and claims writes that fall inside a parameterised address window. The claim comes one cycle later than the fastest possible decode. From the first data phase it signals that it is ready to accept data. Each data phase in which both sides signal ready places the bus data, its byte enables and a running word address into the FIFO.

When the FIFO fills, the block stops the burst. It withdraws its ready signal and raises its stop signal in the same cycle, while the master is still signalling that it wants to continue. It keeps the stop condition until the master has released both its frame and ready lines. It then lets go of its claim and stop lines together, and drives them deasserted for one more cycle before it floats them.

Only after the bus transaction has ended does the block raise a request to a local memory arbiter. It holds that request until a grant arrives, however long that takes. While the grant is present it moves one FIFO word per clock onto a local write port. It drops the request once the last word has left the FIFO.

Top module: `pciBurstSink`

## Requirements
- R1: While reset is held and directly after it, trdyN, stopN and devselN are 1, all three output enables are 0, and memReq and memWrEn are 0.
- R2: A transaction starts on an edge where frameN is sampled 0 after it was 1 on the previous edge; that edge is the address edge. If at that edge cbeN is 4'b0111 (memory write) and adIn lies in [BASE, BASE+SIZE), then devselN and trdyN stay 1 in the cycle after the address edge, and are 0 (with all output enables 1) after the next edge.
- R3: A word enters the FIFO only at an edge where irdyN and trdyN are both 0. An edge with irdyN at 1 stores nothing.
- R4: The edge that stores the DEPTH-th word while frameN is 0 is followed by trdyN 1, stopN 0 and devselN 0. This disconnect holds for as long as frameN or irdyN stays 0.
- R5: No word is stored while stopN is 0, even when irdyN is 0. The drain then delivers exactly the words stored before the disconnect.
- R6: In the disconnect, the first edge with frameN and irdyN both 1 is followed by stopN and devselN both becoming 1 in the same cycle. The output enables stay 1 for that cycle and are 0 after the next edge.
- R7: An edge that stores a word while frameN is 1 (the last data phase) is followed by devselN and trdyN at 1, with stopN never going to 0.
- R8: memReq is 0 while the block claims the bus. It becomes 1 in the cycle after the claim ends and remains 1 while memGnt is 0. memWrEn is 0 whenever memGnt is 0.
- R9: While memReq and memGnt are 1, memWrEn is 1 and one stored word is removed per edge, in storage order. memByteEn is the bitwise inverse of the cbeN sampled in that word's data phase. memReq falls after the edge that removes the last word.
- R10: memAddr of the first stored word equals the address from the address edge. Each further stored word's address is 4 more than the previous one, and edges that store nothing do not advance it.
- R11: A start with any other command, or with an address outside the window, is not claimed: devselN stays 1 and memReq stays 0. The block ignores the bus until an edge with frameN and irdyN both 1, and a following valid start is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| adIn | input | 32 | Multiplexed address/data bus |
| cbeN | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frameN | input | 1 | Master frame, active low |
| irdyN | input | 1 | Master ready, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Target stop (disconnect), active low |
| devselN | output | 1 | Target claim, active low |
| trdyOe | output | 1 | Output enable for trdyN |
| stopOe | output | 1 | Output enable for stopN |
| devselOe | output | 1 | Output enable for devselN |
| memReq | output | 1 | Request to the local memory arbiter |
| memGnt | input | 1 | Grant from the local memory arbiter |
| memWrEn | output | 1 | Local write strobe, one word per clock |
| memAddr | output | 32 | Local write word address |
| memData | output | 32 | Local write data |
| memByteEn | output | 4 | Local write byte enables, active high |

## Verification
The assertions assume a master that follows the bus rules. frameN only rises together with or after the last irdyN assertion. Once irdyN is low it stays low until a handshake or a stop has been seen. The master never starts a new transaction in the cycle after the bus goes idle. The assertions also assume the arbiter only ever grants a pending request. The bench drives every transaction through fixed sequences written to these rules. These include a wait state, a master that keeps irdyN low through the disconnect, and a grant held off for several cycles. No check depends on input combinations that the bus rules forbid.

// File: rtl/pciSinkPkg.sv
package pciSinkPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_DECODE,
    ST_ACTIVE,
    ST_DISC,
    ST_REQ
  } sinkState_t;

  typedef struct packed {
    logic loadAddr;
    logic push;
    logic pop;
  } sinkStrobe_t;

  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

endpackage

// File: rtl/pciSinkCtrl.sv
module pciSinkCtrl
  import pciSinkPkg::*;
#(
  parameter logic [31:0] BASE = 32'h1000_0000,
  parameter logic [31:0] SIZE = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        memGnt,
  input  logic        almostFull,
  input  logic        oneLeft,
  input  logic        empty,
  output sinkStrobe_t strb,
  output logic        trdyN,
  output logic        stopN,
  output logic        devselN,
  output logic        trdyOe,
  output logic        stopOe,
  output logic        devselOe,
  output logic        memReq,
  output logic        memWrEn
);

  sinkState_t state, stateNext;
  logic frameQ;
  logic turnQ;
  logic start;
  logic hit;
  logic busDone;

  assign start   = frameQ && !frameN;
  assign hit     = ((adIn - BASE) < SIZE) && (cbeN == CMD_MEM_WRITE);
  assign busDone = frameN && irdyN;

  // Strobes toward the datapath
  assign strb.loadAddr = (state == ST_IDLE) && start;
  assign strb.push     = (state == ST_ACTIVE) && !irdyN;
  assign strb.pop      = memWrEn;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = hit ? ST_DECODE : ST_SKIP;
      ST_SKIP:   if (busDone) stateNext = ST_IDLE;
      ST_DECODE: stateNext = ST_ACTIVE;
      ST_ACTIVE: begin
        if (!irdyN) begin
          if (frameN)          stateNext = ST_REQ;
          else if (almostFull) stateNext = ST_DISC;
        end
      end
      ST_DISC:   if (busDone) stateNext = ST_REQ;
      ST_REQ:    if (empty || (memWrEn && oneLeft)) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      frameQ <= 1'b1;
      turnQ  <= 1'b0;
    end else begin
      state  <= stateNext;
      frameQ <= frameN;
      turnQ  <= ((state == ST_ACTIVE) || (state == ST_DISC)) && (stateNext == ST_REQ);
    end
  end

  // Bus outputs, decoded from state only
  assign devselN  = !((state == ST_ACTIVE) || (state == ST_DISC));
  assign trdyN    = !(state == ST_ACTIVE);
  assign stopN    = !(state == ST_DISC);
  assign devselOe = (state == ST_ACTIVE) || (state == ST_DISC) || turnQ;
  assign trdyOe   = devselOe;
  assign stopOe   = devselOe;

  // Local side
  assign memReq  = (state == ST_REQ) && !empty;
  assign memWrEn = memReq && memGnt;

  // R2: claim appears two edges after the start edge
  a_r2_claim_delay: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> $past(frameN, 2) == 1'b0 && $past(devselN, 2));

  // R4: a disconnect begins only after a handshake on a continuing burst
  a_r4_stop_after_full: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopN) |-> $past(!irdyN && !trdyN && !frameN && almostFull));

  // R6: stop and claim are released together, only once the master is idle
  a_r6_release_together: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopN) |-> $rose(devselN) && $past(frameN && irdyN));

  // R8: a pending request is held until granted
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq);

  // R8: never request memory while claiming the bus
  a_r8_no_req_on_bus: assert property (@(posedge clk) disable iff (!rstN)
    !devselN |-> !memReq);

endmodule

// File: rtl/pciSinkData.sv
module pciSinkData
  import pciSinkPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  sinkStrobe_t strb,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  output logic        almostFull,
  output logic        oneLeft,
  output logic        empty,
  output logic [31:0] memAddr,
  output logic [31:0] memData,
  output logic [3:0]  memByteEn
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [31:0] addrMem [DEPTH];
  logic [31:0] dataMem [DEPTH];
  logic [3:0]  beMem   [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [31:0] wordAddr;

  assign empty      = (count == '0);
  assign oneLeft    = (count == CNT_W'(1));
  assign almostFull = (count == FULL_CNT - CNT_W'(1));

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strb.push && (wrPtr == PTR_W'(i))) begin
          addrMem[i] <= wordAddr;
          dataMem[i] <= adIn;
          beMem[i]   <= ~cbeN;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      wordAddr <= '0;
    end else begin
      if (strb.loadAddr) wordAddr <= adIn;
      else if (strb.push) wordAddr <= wordAddr + 32'd4;
      if (strb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (strb.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
    end
  end

  assign memAddr   = addrMem[rdPtr];
  assign memData   = dataMem[rdPtr];
  assign memByteEn = beMem[rdPtr];

  // R3: a store never lands in a full FIFO
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> count < FULL_CNT);

  // R9: a local write never reads an empty FIFO
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);

endmodule

// File: rtl/pciBurstSink.sv
module pciBurstSink
  import pciSinkPkg::*;
#(
  parameter logic [31:0] BASE  = 32'h1000_0000,
  parameter logic [31:0] SIZE  = 32'h0001_0000,
  parameter int          DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        frameN,
  input  logic        irdyN,
  output logic        trdyN,
  output logic        stopN,
  output logic        devselN,
  output logic        trdyOe,
  output logic        stopOe,
  output logic        devselOe,
  output logic        memReq,
  input  logic        memGnt,
  output logic        memWrEn,
  output logic [31:0] memAddr,
  output logic [31:0] memData,
  output logic [3:0]  memByteEn
);

  sinkStrobe_t strb;
  logic almostFull, oneLeft, empty;

  pciSinkCtrl #(.BASE(BASE), .SIZE(SIZE)) i_ctrl (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeN(cbeN),
    .frameN(frameN), .irdyN(irdyN), .memGnt(memGnt),
    .almostFull(almostFull), .oneLeft(oneLeft), .empty(empty),
    .strb(strb), .trdyN(trdyN), .stopN(stopN), .devselN(devselN),
    .trdyOe(trdyOe), .stopOe(stopOe), .devselOe(devselOe),
    .memReq(memReq), .memWrEn(memWrEn)
  );

  pciSinkData #(.DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .adIn(adIn), .cbeN(cbeN),
    .almostFull(almostFull), .oneLeft(oneLeft), .empty(empty),
    .memAddr(memAddr), .memData(memData), .memByteEn(memByteEn)
  );

endmodule

// File: tb/test_pciBurstSink.sv
module test_pciBurstSink;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] SIZE = 32'h0001_0000;

  // {address, command, expected claim}
  localparam logic [36:0] VEC [6] = '{
    {BASE,                 4'b0111, 1'b1},
    {BASE + SIZE - 32'd4,  4'b0111, 1'b1},
    {BASE + SIZE,          4'b0111, 1'b0},
    {BASE - 32'd4,         4'b0111, 1'b0},
    {BASE + 32'h100,       4'b0110, 1'b0},
    {BASE + 32'h200,       4'b0011, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [31:0] adIn;
  logic [3:0] cbeN;
  logic frameN, irdyN, memGnt;
  logic trdyN, stopN, devselN, trdyOe, stopOe, devselOe;
  logic memReq, memWrEn;
  logic [31:0] memAddr, memData;
  logic [3:0] memByteEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pciBurstSink #(.BASE(BASE), .SIZE(SIZE), .DEPTH(4)) i_pciBurstSink (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeN(cbeN),
    .frameN(frameN), .irdyN(irdyN),
    .trdyN(trdyN), .stopN(stopN), .devselN(devselN),
    .trdyOe(trdyOe), .stopOe(stopOe), .devselOe(devselOe),
    .memReq(memReq), .memGnt(memGnt), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData), .memByteEn(memByteEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; adIn = '0; cbeN = 4'hF; frameN = 1'b1; irdyN = 1'b1; memGnt = 1'b0;
    repeat (3) step();
    // R1: reset state
    chk("R1 idle bus outputs", {trdyN, stopN, devselN}, 3'b111);
    chk("R1 enables", {trdyOe, stopOe, devselOe}, 3'b000);
    chk("R1 local", {memReq, memWrEn}, 2'b00);
    rstN = 1'b1;
    step();
    chk("R1 after reset", {trdyN, stopN, devselN, trdyOe, memReq}, 5'b11100);

    // Table walk: single-word writes, decode window and command (R2, R7, R9, R11)
    for (int v = 0; v < 6; v++) begin
      logic [31:0] a;
      logic [3:0] c;
      logic cl;
      {a, c, cl} = VEC[v];
      frameN = 1'b0; adIn = a; cbeN = c;
      step();
      chk("R2 no claim in decode cycle", devselN, 1'b1);
      irdyN = 1'b0; adIn = 32'hA500_0000 + v; cbeN = 4'b1010;
      step();
      chk(cl ? "R2 claim" : "R11 no claim", {devselN, trdyN}, cl ? 2'b00 : 2'b11);
      frameN = 1'b1;
      step();
      irdyN = 1'b1;
      if (cl) begin
        chk("R7 release after last phase", {devselN, trdyN, stopN}, 3'b111);
        chk("R8 request after end", memReq, 1'b1);
        memGnt = 1'b1;
        #1;
        chk("R9 write strobe", memWrEn, 1'b1);
        chk("R10 first address", memAddr, a);
        chk("R9 data", memData, 32'hA500_0000 + v);
        chk("R9 byte enables", memByteEn, 4'b0101);
        step();
        memGnt = 1'b0;
        chk("R9 request dropped", memReq, 1'b0);
      end else begin
        chk("R11 no request", memReq, 1'b0);
        step();
        chk("R11 still idle", {devselN, memReq}, 2'b10);
      end
      step();
    end

    // Directed burst with wait state and disconnect (R3..R6, R8..R10)
    frameN = 1'b0; adIn = BASE + 32'h40; cbeN = 4'b0111;
    step();
    irdyN = 1'b0; adIn = 32'hD000_0000; cbeN = 4'b0000;
    step();
    chk("R2 burst claim", {devselN, trdyN, devselOe}, 3'b001);
    step();
    irdyN = 1'b1; adIn = 32'hBAD0_0001;        // wait state (R3)
    step();
    irdyN = 1'b0; adIn = 32'hD000_0001; cbeN = 4'b1100;
    step();
    adIn = 32'hD000_0002; cbeN = 4'b0011;
    step();
    adIn = 32'hD000_0003; cbeN = 4'b0101;
    step();
    // the fourth word was stored: disconnect with frame still asserted
    chk("R4 disconnect shape", {trdyN, stopN, devselN}, 3'b100);
    chk("R8 no request in transaction", memReq, 1'b0);
    adIn = 32'hBAD0_0004;
    step();
    chk("R4 disconnect held", {trdyN, stopN, devselN}, 3'b100);
    frameN = 1'b1; adIn = 32'hBAD0_0005;
    step();
    chk("R6 held until irdy released", stopN, 1'b0);
    irdyN = 1'b1;
    step();
    chk("R6 release together", {stopN, devselN}, 2'b11);
    chk("R6 enables for turnaround", {trdyOe, stopOe, devselOe}, 3'b111);
    chk("R8 request raised", memReq, 1'b1);
    step();
    chk("R6 enables off", {trdyOe, stopOe, devselOe}, 3'b000);
    chk("R8 held without grant", {memReq, memWrEn}, 2'b10);
    step();
    chk("R8 still held", {memReq, memWrEn}, 2'b10);
    memGnt = 1'b1;
    for (int w = 0; w < 4; w++) begin
      logic [3:0] expBe [4];
      expBe = '{4'b1111, 4'b0011, 4'b1100, 4'b1010};
      #1;
      chk("R9 drain strobe", memWrEn, 1'b1);
      chk("R10 address step", memAddr, BASE + 32'h40 + 32'(4 * w));
      chk("R3 data order", memData, 32'hD000_0000 + w);
      chk("R9 byte enables", memByteEn, expBe[w]);
      step();
    end
    chk("R5 exactly four words", {memReq, memWrEn}, 2'b00);
    memGnt = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule